// File: doc/BRIEF.md
# Paged Address Translator with Table Walk

This block converts 24-bit virtual addresses into 32-bit physical addresses. It reads a single-level page table from memory through a word-wide memory port. A requester presents a virtual address and a read/write flag. The translator fetches the table entry for that page, checks the entry, and returns either a physical address or a fault code. Three configuration values set the translation context: the table base address, the table length in entries, and a translation enable bit. They are loaded together with one strobe.

Pages are 8 KB. The low 13 bits of the virtual address are the byte offset, and the 11 bits above them are the page number. Each table entry is one 32-bit word at the table base plus four times the page number. The frame number sits in entry bits 31..13 and the status flags in bits 3..0. When an access succeeds and the entry's accessed or modified flags need setting, the translator writes the entry back itself. All other bits of the entry are preserved.

The translator handles one request at a time. With translation disabled, the virtual address is returned zero-extended and memory is not touched.

Top module: `pgw_xlate`

## Requirements
- R1: With translation on, a successful access returns fault code 0 and a physical address equal to entry bits 31..13 followed by virtual address bits 12..0.
- R2: The entry is read from address table base + 4 × page number, where the page number is virtual address bits 23..13. Address and direction on the memory port stay fixed from the start of a memory request until mem_ack.
- R3: A page number greater than or equal to the table length returns fault code 1 with physical address 0, and no memory access is made. A page number equal to length − 1 is still in range.
- R4: An entry with bit 0 (present) clear returns fault code 2 with physical address 0, and no write-back is made.
- R5: A write access to a present entry with bit 1 (write allowed) clear returns fault code 3 with physical address 0, and no write-back is made. A read of the same entry succeeds.
- R6: A successful access to an entry with bit 2 (accessed) clear writes the entry back once with bit 2 set. All other bits keep the values that were read, including the unused bits 12..4.
- R7: A successful write access to an entry with bit 3 (modified) clear sets bit 3 and bit 2 in one single write-back.
- R8: A successful access needs no write-back when bit 2 is already set and, for writes, bit 3 is already set. In that case no memory write is made.
- R9: With translation disabled, the response has fault code 0 and the virtual address zero-extended to 32 bits, and no memory access is made.
- R10: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0. req_ready is 1 only when the translator is idle, and a request is taken only then. Each accepted request yields exactly one rsp_valid pulse of one cycle.
- R11: A cycle with cfg_we high loads the base, the length and the enable bit together. Requests accepted afterwards use the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the three configuration values |
| cfg_tbl_base | input | 32 | Page table base byte address |
| cfg_tbl_len | input | 12 | Page table length in entries (0..2048) |
| cfg_xlat_en | input | 1 | 1 = translate, 0 = pass the address through |
| req_valid | input | 1 | Request present; taken when req_ready is 1 |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 24 | Virtual address |
| req_ready | output | 1 | Translator idle and able to take a request |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 2 | 0 ok, 1 out of range, 2 not present, 3 write denied |
| rsp_paddr | output | 32 | Physical address; 0 on a fault |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry value to write back |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Entry value read, valid with mem_ack |

## Verification
The bench targets these corner cases:
- The length boundary. It uses page number length − 1, page number length, the top page with a short table, and length 0. A comparison off by one would fetch an entry it should reject, or fault on the last valid entry.
- The write-back flags. One entry is read, then written, then written again. Another entry is first touched by a write. A design that set the flags in separate writes, skipped setting the modified flag on a first write, or rewrote an entry whose flags were already set would show a wrong write count or a wrong word.
- A table entry with unusual unused bits. If its final memory value changes, the write-back damaged the unused field.
- Fault priority. A write to a read-only entry must report the write-denied fault, while a read of the same entry still succeeds.
- Pass-through mode. It must touch no memory.
- A stray request pulse while busy. It must not produce a second response.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_RANGE   = 2'd1,
      FLT_ABSENT  = 2'd2,
      FLT_WDENIED = 2'd3
   } pgw_fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_EVAL,
      ST_WBACK,
      ST_RESP
   } pgw_state_e;

   localparam int FLAG_PRESENT  = 0;
   localparam int FLAG_WRITABLE = 1;
   localparam int FLAG_ACCESSED = 2;
   localparam int FLAG_MODIFIED = 3;
   localparam int FLAG_COUNT    = 4;

endpackage

// File: rtl/pgw_cfg_regs.sv
module pgw_cfg_regs #(
   parameter int PA_W  = 32,
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [PA_W-1:0]  cfg_base,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             cfg_en,
   output logic [PA_W-1:0]  base_q,
   output logic [LEN_W-1:0] len_q,
   output logic             en_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
         en_q   <= 1'b0;
      end else if (cfg_we) begin
         base_q <= cfg_base;
         len_q  <= cfg_len;
         en_q   <= cfg_en;
      end
   end

endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
   parameter int VA_W      = 24,
   parameter int OFF_W     = 13,
   parameter int PA_W      = 32,
   parameter int WORD_W    = 32,
   parameter bit LEN_CHECK = 1'b1
) (
   input  logic [VA_W-1:0]        vaddr,
   input  logic [PA_W-1:0]        base,
   input  logic [VA_W-OFF_W:0]    len,
   output logic                   in_range,
   output logic [PA_W-1:0]        ent_addr
);

   localparam int PN_W   = VA_W - OFF_W;
   localparam int ENT_LG = $clog2(WORD_W / 8);

   logic [PN_W-1:0] pn;
   logic [PA_W-1:0] pn_ext;

   assign pn       = vaddr[VA_W-1:OFF_W];
   assign pn_ext   = {{(PA_W-PN_W){1'b0}}, pn};
   assign ent_addr = base + (pn_ext << ENT_LG);

   generate
      if (LEN_CHECK) begin : g_bounded
         assign in_range = ({1'b0, pn} < len);
      end else begin : g_unbounded
         logic unused_len;
         assign unused_len = ^len;
         assign in_range   = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pgw_pte_eval.sv
module pgw_pte_eval
   import pgw_pkg::*;
#(
   parameter int OFF_W  = 13,
   parameter int PA_W   = 32,
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] pte,
   input  logic [OFF_W-1:0]  offset,
   input  logic              is_write,
   output pgw_fault_e        fault,
   output logic              needs_wb,
   output logic [WORD_W-1:0] new_pte,
   output logic [PA_W-1:0]   paddr
);

   localparam int FRAME_W = PA_W - OFF_W;

   logic [FRAME_W-1:0] frame;
   logic               set_acc;
   logic               set_mod;
   logic [WORD_W-1:0]  set_mask;

   assign frame = pte[WORD_W-1 -: FRAME_W];
   assign paddr = {frame, offset};

   always_comb begin
      if (!pte[FLAG_PRESENT])
         fault = FLT_ABSENT;
      else if (is_write && !pte[FLAG_WRITABLE])
         fault = FLT_WDENIED;
      else
         fault = FLT_NONE;
   end

   assign set_acc  = !pte[FLAG_ACCESSED];
   assign set_mod  = is_write && !pte[FLAG_MODIFIED];
   assign needs_wb = set_acc || set_mod;

   always_comb begin
      set_mask = '0;
      set_mask[FLAG_ACCESSED] = 1'b1;
      set_mask[FLAG_MODIFIED] = is_write;
   end

   assign new_pte = pte | set_mask;

endmodule

// File: rtl/pgw_xlate.sv
module pgw_xlate
   import pgw_pkg::*;
#(
   parameter int VA_W      = 24,
   parameter int OFF_W     = 13,
   parameter int PA_W      = 32,
   parameter int WORD_W    = 32,
   parameter bit LEN_CHECK = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [PA_W-1:0]        cfg_tbl_base,
   input  logic [VA_W-OFF_W:0]    cfg_tbl_len,
   input  logic                   cfg_xlat_en,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [VA_W-1:0]        req_vaddr,
   output logic                   req_ready,
   output logic                   rsp_valid,
   output logic [1:0]             rsp_fault,
   output logic [PA_W-1:0]        rsp_paddr,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [PA_W-1:0]        mem_addr,
   output logic [WORD_W-1:0]      mem_wdata,
   input  logic                   mem_ack,
   input  logic [WORD_W-1:0]      mem_rdata
);

   localparam int PN_W    = VA_W - OFF_W;
   localparam int LEN_W   = PN_W + 1;
   localparam int FRAME_W = PA_W - OFF_W;

   initial begin
      assert (PA_W >= VA_W) else $fatal(1, "physical width below virtual width");
      assert (PA_W > PN_W) else $fatal(1, "physical width too small for page index");
      assert (WORD_W >= FRAME_W + FLAG_COUNT) else $fatal(1, "entry word too narrow");
      assert (WORD_W % 8 == 0) else $fatal(1, "entry word not whole bytes");
      assert (OFF_W > 0 && PN_W > 0) else $fatal(1, "bad address split");
   end

   logic [PA_W-1:0]   base_q;
   logic [LEN_W-1:0]  len_q;
   logic              en_q;

   pgw_cfg_regs #(.PA_W(PA_W), .LEN_W(LEN_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_base (cfg_tbl_base),
      .cfg_len  (cfg_tbl_len),
      .cfg_en   (cfg_xlat_en),
      .base_q   (base_q),
      .len_q    (len_q),
      .en_q     (en_q)
   );

   logic              in_range;
   logic [PA_W-1:0]   ent_addr;

   pgw_addr_gen #(
      .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .WORD_W(WORD_W), .LEN_CHECK(LEN_CHECK)
   ) u_agen (
      .vaddr    (req_vaddr),
      .base     (base_q),
      .len      (len_q),
      .in_range (in_range),
      .ent_addr (ent_addr)
   );

   pgw_state_e        state;
   logic [VA_W-1:0]   va_q;
   logic              wr_q;
   logic              xl_on_q;
   logic [PA_W-1:0]   ent_addr_q;
   logic [WORD_W-1:0] pte_q;
   logic [WORD_W-1:0] wdata_q;
   pgw_fault_e        fault_q;
   logic [PA_W-1:0]   paddr_q;

   pgw_fault_e        ev_fault;
   logic              ev_wb;
   logic [WORD_W-1:0] ev_pte;
   logic [PA_W-1:0]   ev_paddr;

   pgw_pte_eval #(.OFF_W(OFF_W), .PA_W(PA_W), .WORD_W(WORD_W)) u_eval (
      .pte      (pte_q),
      .offset   (va_q[OFF_W-1:0]),
      .is_write (wr_q),
      .fault    (ev_fault),
      .needs_wb (ev_wb),
      .new_pte  (ev_pte),
      .paddr    (ev_paddr)
   );

   logic [PA_W-1:0] pass_addr;

   generate
      if (PA_W > VA_W) begin : g_pass_ext
         assign pass_addr = {{(PA_W-VA_W){1'b0}}, req_vaddr};
      end else begin : g_pass_eq
         assign pass_addr = req_vaddr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         va_q       <= '0;
         wr_q       <= 1'b0;
         xl_on_q    <= 1'b0;
         ent_addr_q <= '0;
         pte_q      <= '0;
         wdata_q    <= '0;
         fault_q    <= FLT_NONE;
         paddr_q    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  wr_q    <= req_write;
                  xl_on_q <= en_q;
                  if (!en_q) begin
                     paddr_q <= pass_addr;
                     fault_q <= FLT_NONE;
                     state   <= ST_RESP;
                  end else if (!in_range) begin
                     paddr_q <= '0;
                     fault_q <= FLT_RANGE;
                     state   <= ST_RESP;
                  end else begin
                     ent_addr_q <= ent_addr;
                     state      <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  pte_q <= mem_rdata;
                  state <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               fault_q <= ev_fault;
               wdata_q <= ev_pte;
               if (ev_fault == FLT_NONE) begin
                  paddr_q <= ev_paddr;
                  state   <= ev_wb ? ST_WBACK : ST_RESP;
               end else begin
                  paddr_q <= '0;
                  state   <= ST_RESP;
               end
            end
            ST_WBACK: begin
               if (mem_ack)
                  state <= ST_RESP;
            end
            ST_RESP: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign rsp_valid = (state == ST_RESP);
   assign rsp_fault = fault_q;
   assign rsp_paddr = paddr_q;
   assign mem_req   = (state == ST_FETCH) || (state == ST_WBACK);
   assign mem_we    = (state == ST_WBACK);
   assign mem_addr  = ent_addr_q;
   assign mem_wdata = wdata_q;

endmodule

// File: rtl/pgw_xlate_chk.sv
module pgw_xlate_chk #(
   parameter int VA_W   = 24,
   parameter int PA_W   = 32,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [1:0]        rsp_fault,
   input logic [PA_W-1:0]   rsp_paddr,
   input logic              mem_req,
   input logic              mem_we,
   input logic [PA_W-1:0]   mem_addr,
   input logic [WORD_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              xl_on_q,
   input logic              wr_q,
   input logic [VA_W-1:0]   va_q
);

   // R10
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req && !rsp_valid));

   // R10
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R2
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R9
   pass_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> xl_on_q);

   // R9
   pass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !xl_on_q) |-> (rsp_fault == 2'd0 && rsp_paddr == PA_W'(va_q)));

   // R6
   wb_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[2] && mem_wdata[0]));

   // R7
   wb_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && wr_q) |-> mem_wdata[3]);

   // R4
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

endmodule

bind pgw_xlate pgw_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_fault (rsp_fault),
   .rsp_paddr (rsp_paddr),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .xl_on_q   (xl_on_q),
   .wr_q      (wr_q),
   .va_q      (va_q)
);

// File: tb/tb_pgw_xlate.sv
module tb_pgw_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_tbl_base = '0;
   logic [11:0] cfg_tbl_len = '0;
   logic        cfg_xlat_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [23:0] req_vaddr = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic [1:0]  rsp_fault;
   logic [31:0] rsp_paddr;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #5 clk = ~clk;

   pgw_xlate dut (.*);

   typedef struct {
      logic [31:0] paddr;
      logic [1:0]  flt;
      bit          rd;
      logic [31:0] rd_addr;
      bit          wb;
      logic [31:0] wdata;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [31:0] ptmem [0:63];
   int          checks = 0;
   int          errors = 0;
   int          rd_seen = 0;
   int          wr_seen = 0;
   logic [31:0] rd_addr_seen = '0;
   logic [31:0] wr_data_seen = '0;
   logic [31:0] m_base = '0;
   logic [11:0] m_len = '0;
   bit          m_en = 1'b0;
   bit          done = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // memory model and result monitor
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         if (mem_we) begin
            ptmem[mem_addr[7:2]] = mem_wdata;
            wr_seen++;
            wr_data_seen = mem_wdata;
         end else begin
            mem_rdata = ptmem[mem_addr[7:2]];
            rd_seen++;
            rd_addr_seen = mem_addr;
         end
         mem_ack = 1'b1;
      end
      if (rsp_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R10", "unexpected response", {30'd0, rsp_fault}, 32'hFFFF_FFFF);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rsp_fault == e.flt, e.tag, "fault", {30'd0, rsp_fault}, {30'd0, e.flt});
            chk(rsp_paddr == e.paddr, e.tag, "paddr", rsp_paddr, e.paddr);
            chk(rd_seen == (e.rd ? 1 : 0), e.tag, "read count", rd_seen, e.rd ? 1 : 0);
            if (e.rd)
               chk(rd_addr_seen == e.rd_addr, e.tag, "entry addr", rd_addr_seen, e.rd_addr);
            chk(wr_seen == (e.wb ? 1 : 0), e.tag, "write count", wr_seen, e.wb ? 1 : 0);
            if (e.wb)
               chk(wr_data_seen == e.wdata, e.tag, "write data", wr_data_seen, e.wdata);
         end
         rd_seen = 0;
         wr_seen = 0;
      end
   end

   task automatic setcfg(input logic [31:0] b, input logic [11:0] l, input bit en);
      @(negedge clk);
      cfg_we = 1'b1; cfg_tbl_base = b; cfg_tbl_len = l; cfg_xlat_en = en;
      @(negedge clk);
      cfg_we = 1'b0;
      m_base = b; m_len = l; m_en = en;
   endtask

   task automatic xact(input logic [23:0] va, input bit wr, input string tag);
      exp_t        e;
      logic [10:0] pn;
      logic [31:0] pte;
      logic [31:0] nw;
      while (sb.size() != 0) @(negedge clk);
      pn = va[23:13];
      e.tag = tag; e.rd = 0; e.wb = 0; e.rd_addr = '0; e.wdata = '0;
      e.flt = 2'd0; e.paddr = '0;
      if (!m_en) begin
         e.paddr = {8'd0, va};
      end else if ({1'b0, pn} >= m_len) begin
         e.flt = 2'd1;
      end else begin
         e.rd = 1;
         e.rd_addr = m_base + {19'd0, pn, 2'b00};
         pte = ptmem[e.rd_addr[7:2]];
         if (!pte[0]) e.flt = 2'd2;
         else if (wr && !pte[1]) e.flt = 2'd3;
         else begin
            e.paddr = {pte[31:13], va[12:0]};
            nw = pte | 32'h4 | (wr ? 32'h8 : 32'h0);
            e.wb = (nw != pte);
            e.wdata = nw;
         end
      end
      sb.push_back(e);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      // R10: busy once accepted
      chk(!req_ready, "R10", "ready while busy", {31'd0, req_ready}, 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) ptmem[i] = '0;
      ptmem[0]  = {19'h12345, 9'h1A5, 4'b0011};
      ptmem[1]  = {19'h00ABC, 9'h000, 4'b0010};
      ptmem[2]  = {19'h7FFFF, 9'h155, 4'b0101};
      ptmem[3]  = {19'h00001, 9'h0F0, 4'b0011};
      ptmem[15] = {19'h40000, 9'h000, 4'b1111};
      ptmem[19] = {19'h2AAAA, 9'h1FF, 4'b0001};
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1, "R10", "reset ready", {31'd0, req_ready}, 32'd1);
      chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk(mem_req == 1'b0, "R10", "reset mem_req", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      setcfg(32'h1000, 12'd16, 1'b0);
      xact(24'hABCDEF, 1'b1, "R9");
      setcfg(32'h1000, 12'd16, 1'b1);
      xact({11'd0, 13'h0123}, 1'b0, "R6");
      xact({11'd0, 13'h1FFF}, 1'b1, "R7");
      xact({11'd0, 13'h0040}, 1'b1, "R8");
      xact({11'd1, 13'h0004}, 1'b0, "R4");
      xact({11'd2, 13'h0ABC}, 1'b0, "R5");
      xact({11'd2, 13'h0ABC}, 1'b1, "R5");
      xact({11'd3, 13'h1000}, 1'b1, "R7");
      xact({11'd15, 13'h0777}, 1'b0, "R3");
      xact({11'd16, 13'h0000}, 1'b0, "R3");
      xact({11'd2047, 13'h0001}, 1'b1, "R3");
      xact({11'd0, 13'h0008}, 1'b0, "R1");
      // stray request while busy must be dropped
      @(negedge clk);
      if (!req_ready) begin
         req_valid = 1'b1; req_vaddr = {11'd3, 13'h0}; req_write = 1'b0;
         @(negedge clk);
         req_valid = 1'b0;
      end
      setcfg(32'h1040, 12'd16, 1'b1);
      xact({11'd3, 13'h0010}, 1'b0, "R2");
      xact({11'd3, 13'h0010}, 1'b1, "R5");
      setcfg(32'h1000, 12'd0, 1'b1);
      xact({11'd0, 13'h0000}, 1'b0, "R3");
      setcfg(32'h1000, 12'd16, 1'b0);
      xact(24'h00_2000, 1'b0, "R11");
      while (sb.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      // R6 unused field kept, flags merged
      chk(ptmem[0] == {19'h12345, 9'h1A5, 4'b1111}, "R6", "final entry 0", ptmem[0],
          {19'h12345, 9'h1A5, 4'b1111});
      chk(ptmem[2] == {19'h7FFFF, 9'h155, 4'b0101}, "R5", "final entry 2", ptmem[2],
          {19'h7FFFF, 9'h155, 4'b0101});
      chk(ptmem[3] == {19'h00001, 9'h0F0, 4'b1111}, "R7", "final entry 3", ptmem[3],
          {19'h00001, 9'h0F0, 4'b1111});
      chk(ptmem[19] == {19'h2AAAA, 9'h1FF, 4'b0101}, "R2", "final entry 19", ptmem[19],
          {19'h2AAAA, 9'h1FF, 4'b0101});
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule